// File: doc/BRIEF.md
# Impedance Sweep Register Engine

This block is the device-side control core of a swept-frequency impedance measurement front end. A host reaches it through a plain synchronous byte port: an address, write data, a write strobe, a read strobe and read data that is valid in the same cycle as the address. Behind that port are the sweep settings, a control byte and a status byte. A command nibble written into the control byte starts, steps, repeats or abandons a frequency point, or requests a temperature reading.

For every measured point the engine first waits a programmable number of settling cycles. It then latches the real, imaginary and temperature words that a measurement stub drives on its input ports, and raises a data-valid flag. A 24-bit frequency code on an output port follows the sweep so that a downstream tone generator can use it. The engine counts the increments taken since the start point. The point reached after the programmed number of increments is flagged as sweep complete.

Top module: `imp_sweep_regs`

## Requirements
- R1: After the asynchronous reset every readable register, the status byte and `freq_code` are zero.
- R2: The configuration registers read back what was written, multi-byte values most significant byte first: control 0x80/0x81, start code 0x82–0x84, increment code 0x85–0x87, increment count 0x88–0x89 (only bit 0 of 0x88 is kept, 9 bits in total), settle word 0x8A–0x8B (only bits [2:0] of 0x8A are kept, 11 bits in total).
- R3: A write to 0x80 whose bits [7:4] are 0x1 (initialise) or 0x2 (start sweep) loads the start code into `freq_code` at that write's clock edge.
- R4: Command 0x3 (increment) adds the increment code to `freq_code` modulo 2^24. Command 0x4 (repeat) leaves `freq_code` unchanged.
- R5: After commands 0x2, 0x3 and 0x4, status bit 1 (data valid) rises exactly E+1 cycles after the command's write edge. E is the settle base (bits [8:0]) times 1, 2 or 4 for a multiplier field (bits [10:9]) of 00, 01 or 11, and times 1 for 10. The real and imaginary inputs are captured at the same edge and read at 0x94/0x95 and 0x96/0x97.
- R6: A read strobe at 0x94 clears data valid. Any defined command also clears it.
- R7: Status bit 2 (sweep complete) is set when a point finishes with at least the programmed count of increments taken since the last start. Commands 0x1 and 0x2 clear it.
- R8: Command 0x9 sets status bit 0 (temperature valid) one edge after the write and captures the temperature input, which reads at 0x92/0x93.
- R9: Writing 0x81 with bit 4 set clears the status byte, `freq_code` and the increment counter. Bit 4 reads back as 0 and the other bits of 0x81 are kept.
- R10: Writes to read-only addresses (0x8F, 0x92–0x97) change nothing. Reads of any unmapped address return 0x00.
- R11: Command 0xA (power down) or 0xB (standby) issued while a point is settling abandons the point, so data valid stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only) |
| rdata | output | 8 | Read data for `addr`, combinational |
| res_real | input | 16 | Real result from the measurement stub |
| res_imag | input | 16 | Imaginary result from the measurement stub |
| res_temp | input | 16 | Temperature result from the measurement stub |
| freq_code | output | 24 | Current excitation frequency code |

## Verification
The bench measures the exact data-valid latency for each multiplier code, including the reserved code 10 and a zero base. A counter that is off by one, or a multiplier applied in the wrong direction, fails those checks by a cycle count. It walks a two-increment sweep and checks that the complete flag stays low on the first two points, so a comparison against the count that is one too early shows up at once. It also runs a sweep with a count of zero. Frequency wrap-around, the clearing of data valid by a read and by a command, an abandoned settle, and writes aimed at result and status bytes are each probed at the ports. A design that leaked a write into a result byte, or kept the reset bit set, returns a wrong byte.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int FREQ_W = 24;
  localparam int STEP_W = 9;
  localparam int BASE_W = 9;
  localparam int RES_W  = 16;
  localparam int SETW_W = BASE_W + 2;
  localparam int CNT_W  = BASE_W + 2;

  localparam logic [7:0] A_CTRL_HI = 8'h80;
  localparam logic [7:0] A_CTRL_LO = 8'h81;
  localparam logic [7:0] A_START   = 8'h82;
  localparam logic [7:0] A_INC     = 8'h85;
  localparam logic [7:0] A_NUM     = 8'h88;
  localparam logic [7:0] A_SETTLE  = 8'h8A;
  localparam logic [7:0] A_STATUS  = 8'h8F;
  localparam logic [7:0] A_TEMP    = 8'h92;
  localparam logic [7:0] A_REAL    = 8'h94;
  localparam logic [7:0] A_IMAG    = 8'h96;

  typedef enum logic [3:0] {
    OP_INIT   = 4'h1,
    OP_START  = 4'h2,
    OP_STEP   = 4'h3,
    OP_REPEAT = 4'h4,
    OP_TEMP   = 4'h9,
    OP_PDOWN  = 4'hA,
    OP_STBY   = 4'hB
  } op_e;

  typedef enum logic {S_IDLE = 1'b0, S_SETTLE = 1'b1} phase_e;

  function automatic logic op_known(input logic [3:0] c);
    return c inside {OP_INIT, OP_START, OP_STEP, OP_REPEAT, OP_TEMP, OP_PDOWN, OP_STBY};
  endfunction
endpackage

// File: rtl/isr_regfile.sv
module isr_regfile
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [7:0]        ctrl_hi,
  output logic [7:0]        ctrl_lo,
  output logic [FREQ_W-1:0] start_code,
  output logic [FREQ_W-1:0] inc_code,
  output logic [STEP_W-1:0] step_num,
  output logic [SETW_W-1:0] settle_word,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic              soft_rst
);
  localparam int NB = FREQ_W / 8;

  logic [7:0]        ctrl_hi_n, ctrl_lo_n;
  logic [FREQ_W-1:0] start_n, inc_n;
  logic [STEP_W-1:0] num_n;
  logic [SETW_W-1:0] settle_n;

  assign cmd_code  = wdata[7:4];
  assign cmd_valid = wr_en && (addr == A_CTRL_HI) && op_known(wdata[7:4]);
  assign soft_rst  = wr_en && (addr == A_CTRL_LO) && wdata[4];

  always_comb begin
    ctrl_hi_n = ctrl_hi;
    ctrl_lo_n = ctrl_lo;
    start_n   = start_code;
    inc_n     = inc_code;
    num_n     = step_num;
    settle_n  = settle_word;
    if (wr_en) begin
      if (addr == A_CTRL_HI) ctrl_hi_n = wdata;
      if (addr == A_CTRL_LO) ctrl_lo_n = wdata & 8'hEF;
      for (int b = 0; b < NB; b++) begin
        if (addr == A_START + 8'(b)) start_n[8*(NB-1-b) +: 8] = wdata;
        if (addr == A_INC + 8'(b))   inc_n[8*(NB-1-b) +: 8]   = wdata;
      end
      if (addr == A_NUM)           num_n[STEP_W-1:8]    = wdata[STEP_W-9:0];
      if (addr == A_NUM + 8'd1)    num_n[7:0]           = wdata;
      if (addr == A_SETTLE)        settle_n[SETW_W-1:8] = wdata[SETW_W-9:0];
      if (addr == A_SETTLE + 8'd1) settle_n[7:0]        = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_hi     <= '0;
      ctrl_lo     <= '0;
      start_code  <= '0;
      inc_code    <= '0;
      step_num    <= '0;
      settle_word <= '0;
    end else if (wr_en) begin
      ctrl_hi     <= ctrl_hi_n;
      ctrl_lo     <= ctrl_lo_n;
      start_code  <= start_n;
      inc_code    <= inc_n;
      step_num    <= num_n;
      settle_word <= settle_n;
    end
  end
endmodule

// File: rtl/isr_sweep.sv
module isr_sweep
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic              soft_rst,
  input  logic              rd_clr,
  input  logic [FREQ_W-1:0] start_code,
  input  logic [FREQ_W-1:0] inc_code,
  input  logic [STEP_W-1:0] step_num,
  input  logic [SETW_W-1:0] settle_word,
  input  logic [RES_W-1:0]  res_real,
  input  logic [RES_W-1:0]  res_imag,
  input  logic [RES_W-1:0]  res_temp,
  output logic [FREQ_W-1:0] freq_code,
  output logic [2:0]        status,
  output logic [RES_W-1:0]  real_q,
  output logic [RES_W-1:0]  imag_q,
  output logic [RES_W-1:0]  temp_q,
  output logic              meas_done
);
  phase_e            ph_q, ph_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, eff;
  logic [STEP_W-1:0] steps_q, steps_n;
  logic [FREQ_W-1:0] acc_n;
  logic [2:0]        stat_n;
  logic [RES_W-1:0]  real_n, imag_n, temp_n;

  always_comb begin
    case (settle_word[SETW_W-1 -: 2])
      2'b01:   eff = CNT_W'(settle_word[BASE_W-1:0]) << 1;
      2'b11:   eff = CNT_W'(settle_word[BASE_W-1:0]) << 2;
      default: eff = CNT_W'(settle_word[BASE_W-1:0]);
    endcase
  end

  assign meas_done = (ph_q == S_SETTLE) && (cnt_q == '0) && !soft_rst && !cmd_valid;

  always_comb begin
    ph_n    = ph_q;
    cnt_n   = cnt_q;
    steps_n = steps_q;
    acc_n   = freq_code;
    stat_n  = status;
    real_n  = real_q;
    imag_n  = imag_q;
    temp_n  = temp_q;
    if (soft_rst) begin
      ph_n    = S_IDLE;
      acc_n   = '0;
      steps_n = '0;
      stat_n  = '0;
    end else if (cmd_valid) begin
      stat_n[1] = 1'b0;
      case (cmd_code)
        OP_INIT:   begin acc_n = start_code; steps_n = '0; stat_n[2] = 1'b0; ph_n = S_IDLE; end
        OP_START:  begin acc_n = start_code; steps_n = '0; stat_n[2] = 1'b0;
                         cnt_n = eff; ph_n = S_SETTLE; end
        OP_STEP:   begin acc_n = freq_code + inc_code;
                         if (steps_q != '1) steps_n = steps_q + 1'b1;
                         cnt_n = eff; ph_n = S_SETTLE; end
        OP_REPEAT: begin cnt_n = eff; ph_n = S_SETTLE; end
        OP_TEMP:   begin stat_n[0] = 1'b1; temp_n = res_temp; end
        default:   ph_n = S_IDLE;
      endcase
    end else begin
      if (rd_clr) stat_n[1] = 1'b0;
      if (ph_q == S_SETTLE) begin
        if (cnt_q == '0) begin
          stat_n[1] = 1'b1;
          stat_n[2] = (steps_q >= step_num);
          real_n    = res_real;
          imag_n    = res_imag;
          ph_n      = S_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= S_IDLE;
      cnt_q     <= '0;
      steps_q   <= '0;
      freq_code <= '0;
      status    <= '0;
      real_q    <= '0;
      imag_q    <= '0;
      temp_q    <= '0;
    end else begin
      ph_q      <= ph_n;
      cnt_q     <= cnt_n;
      steps_q   <= steps_n;
      freq_code <= acc_n;
      status    <= stat_n;
      real_q    <= real_n;
      imag_q    <= imag_n;
      temp_q    <= temp_n;
    end
  end
endmodule

// File: rtl/isr_readmux.sv
module isr_readmux
  import isr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        ctrl_hi,
  input  logic [7:0]        ctrl_lo,
  input  logic [FREQ_W-1:0] start_code,
  input  logic [FREQ_W-1:0] inc_code,
  input  logic [STEP_W-1:0] step_num,
  input  logic [SETW_W-1:0] settle_word,
  input  logic [2:0]        status,
  input  logic [RES_W-1:0]  real_q,
  input  logic [RES_W-1:0]  imag_q,
  input  logic [RES_W-1:0]  temp_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int NB = FREQ_W / 8;

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr == A_START + 8'(b)) rdata = start_code[8*(NB-1-b) +: 8];
      if (addr == A_INC + 8'(b))   rdata = inc_code[8*(NB-1-b) +: 8];
    end
    case (addr)
      A_CTRL_HI:       rdata = ctrl_hi;
      A_CTRL_LO:       rdata = ctrl_lo;
      A_NUM:           rdata = 8'(step_num[STEP_W-1:8]);
      A_NUM + 8'd1:    rdata = step_num[7:0];
      A_SETTLE:        rdata = 8'(settle_word[SETW_W-1:8]);
      A_SETTLE + 8'd1: rdata = settle_word[7:0];
      A_STATUS:        rdata = {5'b0, status};
      A_TEMP:          rdata = temp_q[15:8];
      A_TEMP + 8'd1:   rdata = temp_q[7:0];
      A_REAL:          rdata = real_q[15:8];
      A_REAL + 8'd1:   rdata = real_q[7:0];
      A_IMAG:          rdata = imag_q[15:8];
      A_IMAG + 8'd1:   rdata = imag_q[7:0];
      default:         ;
    endcase
  end
endmodule

// File: rtl/imp_sweep_regs.sv
module imp_sweep_regs
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic [RES_W-1:0]  res_real,
  input  logic [RES_W-1:0]  res_imag,
  input  logic [RES_W-1:0]  res_temp,
  output logic [FREQ_W-1:0] freq_code
);
  logic [7:0]        ctrl_hi, ctrl_lo;
  logic [FREQ_W-1:0] start_code, inc_code;
  logic [STEP_W-1:0] step_num;
  logic [SETW_W-1:0] settle_word;
  logic              cmd_valid, soft_rst, meas_done, rd_clr;
  logic [3:0]        cmd_code;
  logic [2:0]        status;
  logic [RES_W-1:0]  real_q, imag_q, temp_q;

  assign rd_clr = rd_en && (addr == A_REAL);

  isr_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .ctrl_hi(ctrl_hi), .ctrl_lo(ctrl_lo), .start_code(start_code),
    .inc_code(inc_code), .step_num(step_num), .settle_word(settle_word),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .soft_rst(soft_rst)
  );

  isr_sweep u_sweep (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .soft_rst(soft_rst), .rd_clr(rd_clr), .start_code(start_code),
    .inc_code(inc_code), .step_num(step_num), .settle_word(settle_word),
    .res_real(res_real), .res_imag(res_imag), .res_temp(res_temp),
    .freq_code(freq_code), .status(status), .real_q(real_q),
    .imag_q(imag_q), .temp_q(temp_q), .meas_done(meas_done)
  );

  isr_readmux u_rmux (
    .addr(addr), .ctrl_hi(ctrl_hi), .ctrl_lo(ctrl_lo), .start_code(start_code),
    .inc_code(inc_code), .step_num(step_num), .settle_word(settle_word),
    .status(status), .real_q(real_q), .imag_q(imag_q), .temp_q(temp_q),
    .rdata(rdata)
  );
endmodule

// File: rtl/imp_sweep_regs_chk.sv
module imp_sweep_regs_chk
  import isr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [FREQ_W-1:0] freq_code,
  input logic              cmd_valid,
  input logic [3:0]        cmd_code,
  input logic              soft_rst,
  input logic              rd_clr,
  input logic              meas_done,
  input logic [FREQ_W-1:0] inc_code,
  input logic [2:0]        status
);
  a_r4_repeat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_REPEAT) |=> $stable(freq_code));

  a_r4_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == OP_STEP) |=> freq_code == $past(freq_code) + $past(inc_code));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !meas_done) |=> !status[1]);

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (freq_code == '0 && status == '0));

  a_r9_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL_LO) |-> !rdata[4]);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr inside {[8'h80:8'h8B], 8'h8F, [8'h92:8'h97]}) |-> rdata == '0);

  a_r5_valid_only_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(meas_done));
endmodule

bind imp_sweep_regs imp_sweep_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .freq_code(freq_code),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .soft_rst(soft_rst),
  .rd_clr(rd_clr), .meas_done(meas_done), .inc_code(inc_code), .status(status)
);

// File: tb/imp_sweep_regs_bench.sv
module imp_sweep_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] res_real = 16'hBEEF;
  logic [15:0] res_imag = 16'h1234;
  logic [15:0] res_temp = 16'h1ABC;
  logic [23:0] freq_code;
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  imp_sweep_regs u_imp_sweep_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .res_real(res_real), .res_imag(res_imag),
    .res_temp(res_temp), .freq_code(freq_code)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b0; #1; v = rdata;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] c);
    wr(8'h80, {c, 4'h0});
  endtask

  task automatic set_settle(input logic [1:0] m, input logic [8:0] base);
    wr(8'h8A, {5'b0, m, base[8]});
    wr(8'h8B, base[7:0]);
  endtask

  task automatic wait_dv(output int k);
    logic [7:0] s;
    k = 0;
    peek(8'h8F, s);
    while (!s[1] && k < 5000) begin
      @(negedge clk); k++; peek(8'h8F, s);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(8'h8F, v); chk("R1 status", v, 0);
    peek(8'h80, v); chk("R1 ctrl hi", v, 0);
    peek(8'h83, v); chk("R1 start mid", v, 0);
    chk("R1 freq_code", freq_code, 0);
  endtask

  task automatic t_map;
    logic [7:0] v;
    wr(8'h82, 8'h12); wr(8'h83, 8'h34); wr(8'h84, 8'h56);
    peek(8'h82, v); chk("R2 start msb", v, 8'h12);
    peek(8'h84, v); chk("R2 start lsb", v, 8'h56);
    wr(8'h88, 8'hFF); peek(8'h88, v); chk("R2 count 9 bits", v, 8'h01);
    wr(8'h8A, 8'hFF); peek(8'h8A, v); chk("R2 settle 11 bits", v, 8'h07);
    wr(8'h80, 8'h07); peek(8'h80, v); chk("R2 ctrl hi range/gain", v, 8'h07);
  endtask

  task automatic t_latency(input logic [1:0] m, input logic [8:0] base, input int exp);
    int k;
    set_settle(m, base);
    cmd(4'h2);
    wait_dv(k);
    chk($sformatf("R5 latency m=%0d base=%0d", m, base), k, exp);
  endtask

  task automatic t_results;
    logic [7:0] v;
    int k;
    set_settle(2'b00, 9'd2);
    cmd(4'h4); wait_dv(k);
    rd(8'h94, v); chk("R5 real msb", v, 8'hBE);
    peek(8'h95, v); chk("R5 real lsb", v, 8'hEF);
    peek(8'h96, v); chk("R5 imag msb", v, 8'h12);
    peek(8'h97, v); chk("R5 imag lsb", v, 8'h34);
    peek(8'h8F, v); chk("R6 read clears valid", v[1], 0);
    cmd(4'h4); wait_dv(k);
    cmd(4'hB); peek(8'h8F, v); chk("R6 command clears valid", v[1], 0);
  endtask

  task automatic t_step;
    int k;
    wr(8'h82, 8'h00); wr(8'h83, 8'h01); wr(8'h84, 8'h00);
    wr(8'h85, 8'h00); wr(8'h86, 8'h00); wr(8'h87, 8'h20);
    set_settle(2'b00, 9'd1);
    cmd(4'h2); chk("R3 start loads code", freq_code, 24'h000100);
    wait_dv(k);
    cmd(4'h3); chk("R4 increment adds", freq_code, 24'h000120);
    wait_dv(k);
    cmd(4'h4); chk("R4 repeat holds", freq_code, 24'h000120);
    wait_dv(k);
    wr(8'h82, 8'hFF); wr(8'h83, 8'hFF); wr(8'h84, 8'hF0);
    cmd(4'h1); chk("R3 init loads code", freq_code, 24'hFFFFF0);
    cmd(4'h3); chk("R4 increment wraps", freq_code, 24'h000010);
    wait_dv(k);
  endtask

  task automatic t_sweep_done;
    logic [7:0] v;
    int k;
    wr(8'h88, 8'h00); wr(8'h89, 8'h02);
    cmd(4'h2); wait_dv(k); peek(8'h8F, v); chk("R7 not done at start", v[2], 0);
    cmd(4'h3); wait_dv(k); peek(8'h8F, v); chk("R7 not done after 1", v[2], 0);
    cmd(4'h3); wait_dv(k); peek(8'h8F, v); chk("R7 done after 2", v[2], 1);
    cmd(4'h1); peek(8'h8F, v); chk("R7 init clears done", v[2], 0);
    wr(8'h89, 8'h00);
    cmd(4'h2); wait_dv(k); peek(8'h8F, v); chk("R7 zero count done", v[2], 1);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    set_settle(2'b00, 9'd20);
    cmd(4'h2);
    repeat (3) @(negedge clk);
    cmd(4'hA);
    repeat (40) @(negedge clk);
    peek(8'h8F, v); chk("R11 power down abandons point", v[1], 0);
  endtask

  task automatic t_temp_ro;
    logic [7:0] v;
    cmd(4'h9);
    peek(8'h8F, v); chk("R8 temp valid", v[0], 1);
    peek(8'h92, v); chk("R8 temp msb", v, 8'h1A);
    peek(8'h93, v); chk("R8 temp lsb", v, 8'hBC);
    wr(8'h8F, 8'h00); peek(8'h8F, v); chk("R10 status write ignored", v[0], 1);
    wr(8'h92, 8'h00); peek(8'h92, v); chk("R10 temp write ignored", v, 8'h1A);
    wr(8'h95, 8'h00); peek(8'h95, v); chk("R10 real write ignored", v, 8'hEF);
    peek(8'h8C, v); chk("R10 unmapped 0x8C", v, 0);
    peek(8'h90, v); chk("R10 unmapped 0x90", v, 0);
    peek(8'hFF, v); chk("R10 unmapped 0xFF", v, 0);
  endtask

  task automatic t_softrst;
    logic [7:0] v;
    wr(8'h81, 8'h18);
    peek(8'h8F, v); chk("R9 status cleared", v, 0);
    chk("R9 freq cleared", freq_code, 0);
    peek(8'h81, v); chk("R9 reset bit reads 0", v, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_latency(2'b00, 9'd5, 6);
    t_latency(2'b01, 9'd3, 7);
    t_latency(2'b11, 9'd3, 13);
    t_latency(2'b10, 9'd3, 4);
    t_latency(2'b00, 9'd0, 1);
    t_results();
    t_step();
    t_sweep_done();
    t_abort();
    t_temp_ro();
    t_softrst();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule